// File: doc/BRIEF.md
# Stream End-Marker Escape Encoder

This block takes a 64-bit packet stream whose packet ends are marked on a separate last-beat wire and turns it into a flat word stream with no sideband. Packet ends travel inside the data. A word that closes a packet is sent as three words: a fixed 64-bit escape value, a flag word meaning "end of packet", and then the data word. A data word that is not the end of a packet but happens to equal the escape value is sent as the escape value, a flag word meaning "literal", and then the data word. Every other word passes through as a single word.

The input side is a valid/ready slave with data, last and valid. The output side is a valid/ready master with data and valid. The output word sits in one register, so output valid never depends combinationally on input valid. While the escape and flag words of a sequence are being produced, the input is stalled. The input word is consumed in the cycle its own data word is loaded into the output register. A synchronous reset, or a synchronous clear, drops any sequence in progress.

Top module: `esc_tlast_encoder`

## Requirements
- R1: An input word with in_tlast low whose value is not 64'hDEADBEEFFEEDCAFE appears on the output as exactly one unchanged word.
- R2: An input word with in_tlast high appears on the output as three words in this order: 64'hDEADBEEFFEEDCAFE, the flag word 64'h0000000000000001, then the input word.
- R3: An input word with in_tlast low whose value equals 64'hDEADBEEFFEEDCAFE appears on the output as 64'hDEADBEEFFEEDCAFE, the flag word 64'h0000000000000000, then the input word.
- R4: When an input word both has in_tlast high and equals 64'hDEADBEEFFEEDCAFE, the end-of-packet form of R2 is used (flag word 64'h1).
- R5: The word that follows a flag word is always the input word as it is, and it is never escaped again, even when it equals the escape value.
- R6: in_tready is low while the escape word and the flag word of a sequence are being loaded. The input word is accepted only in the cycle its data word enters the output register, and that word is on out_tdata with out_tvalid high in the next cycle.
- R7: While out_tvalid is high and out_tready is low, out_tvalid stays high and out_tdata stays unchanged in the next cycle.
- R8: out_tvalid comes from a register. With out_tready held high, plain words (R1) are accepted and sent one per clock cycle.
- R9: One cycle after rst or clear is sampled high, out_tvalid is low and no partial sequence remains. The next input word is encoded from its first output word.
- R10: Decoding the output stream gives back the exact sequence of input words and last flags. This holds with gaps in in_tvalid and random backpressure on out_tready.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| clear | input | 1 | Synchronous active-high clear; same effect as rst |
| in_tdata | input | 64 | Input data word |
| in_tlast | input | 1 | High on the last word of a packet |
| in_tvalid | input | 1 | Input word present |
| in_tready | output | 1 | Block accepts the input word this cycle |
| out_tdata | output | 64 | Encoded output word |
| out_tvalid | output | 1 | Registered output valid |
| out_tready | input | 1 | Downstream accepts the output word |

## Verification
In a single cycle, the output register can hand its word downstream and also be reloaded. It can be reloaded either with the next word of an escape sequence or with the word that ends a sequence and consumes the input. Random out_tready and random in_tvalid gaps are run over streams with many end-of-packet words and escape-valued words. This produces cycles where a transfer, a reload and an input accept all happen together, and also cycles where the register is stalled in the middle of a sequence. Each output word is compared in order with an encoding the bench computes itself. A bench decoder rebuilds the packet stream and compares it with what was sent, and a held word must stay unchanged across each stalled cycle.

// File: rtl/esc_enc_pkg.sv
package esc_enc_pkg;

    localparam int WORD_W     = 64;
    localparam int FLAG_KEY_W = 32;

    localparam logic [WORD_W-1:0] ESC_WORD = 64'hDEADBEEFFEEDCAFE;
    localparam logic [WORD_W-1:0] FLAG_END = {{(WORD_W-FLAG_KEY_W){1'b0}}, {(FLAG_KEY_W-1){1'b0}}, 1'b1};
    localparam logic [WORD_W-1:0] FLAG_LIT = '0;

    // How an input word must be framed on the output side
    typedef enum logic [1:0] {
        KIND_PLAIN = 2'd0,
        KIND_END   = 2'd1,
        KIND_LIT   = 2'd2
    } word_kind_e;

    // Position inside an escape sequence
    typedef enum logic [1:0] {
        SQ_HEAD = 2'd0,
        SQ_FLAG = 2'd1,
        SQ_BODY = 2'd2
    } seq_state_e;

    // Which word the output register loads
    typedef enum logic [1:0] {
        SEL_DATA = 2'd0,
        SEL_ESC  = 2'd1,
        SEL_FLAG = 2'd2
    } word_sel_e;

    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic              last;
    } in_beat_t;

    // End-of-packet framing wins over the literal framing
    function automatic word_kind_e classify(input in_beat_t b);
        if (b.last)                 return KIND_END;
        else if (b.data == ESC_WORD) return KIND_LIT;
        else                        return KIND_PLAIN;
    endfunction

    function automatic logic [WORD_W-1:0] flag_for(input word_kind_e k);
        return (k == KIND_END) ? FLAG_END : FLAG_LIT;
    endfunction

    function automatic logic [WORD_W-1:0] pick_word(input word_sel_e s,
                                                    input word_kind_e k,
                                                    input logic [WORD_W-1:0] d);
        logic [WORD_W-1:0] w;
        case (s)
            SEL_ESC:  w = ESC_WORD;
            SEL_FLAG: w = flag_for(k);
            default:  w = d;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/esc_classify.sv
module esc_classify
    import esc_enc_pkg::*;
(
    input  logic [WORD_W-1:0] beat_data,
    input  logic              beat_last,
    output word_kind_e        beat_kind
);
    in_beat_t beat;

    always_comb begin
        beat.data = beat_data;
        beat.last = beat_last;
        beat_kind = classify(beat);
    end
endmodule

// File: rtl/esc_sequencer.sv
module esc_sequencer
    import esc_enc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       flush,
    input  logic       in_valid,
    input  word_kind_e kind,
    input  logic       slot_free,
    output logic       want,
    output word_sel_e  sel,
    output logic       accept,
    output seq_state_e state
);
    seq_state_e state_q, state_d;

    always_comb begin
        want    = 1'b0;
        sel     = SEL_DATA;
        accept  = 1'b0;
        state_d = state_q;
        case (state_q)
            SQ_HEAD: begin
                if (in_valid) begin
                    want = 1'b1;
                    if (kind == KIND_PLAIN) begin
                        sel    = SEL_DATA;
                        accept = slot_free;
                    end else begin
                        sel = SEL_ESC;
                        if (slot_free) state_d = SQ_FLAG;
                    end
                end
            end
            SQ_FLAG: begin
                want = 1'b1;
                sel  = SEL_FLAG;
                if (slot_free) state_d = SQ_BODY;
            end
            SQ_BODY: begin
                // data after a flag is never re-escaped (R5)
                want   = 1'b1;
                sel    = SEL_DATA;
                accept = slot_free;
                if (slot_free) state_d = SQ_HEAD;
            end
            default: state_d = SQ_HEAD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || flush) state_q <= SQ_HEAD;
        else              state_q <= state_d;
    end

    assign state = state_q;

    // R6: a started sequence always runs escape -> flag -> data
    a_r6_flag_follows_esc: assert property (@(posedge clk) disable iff (rst || flush)
        (state_q == SQ_HEAD && want && sel == SEL_ESC && slot_free) |=> (state_q == SQ_FLAG));
endmodule

// File: rtl/esc_out_stage.sv
module esc_out_stage
    import esc_enc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              load,
    input  logic [WORD_W-1:0] load_data,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_data,
    output logic              slot_free
);
    logic              valid_q;
    logic [WORD_W-1:0] data_q;

    assign slot_free = !valid_q || out_ready;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            valid_q <= 1'b0;
            data_q  <= '0;
        end else if (slot_free) begin
            valid_q <= load;
            if (load) data_q <= load_data;
        end
    end

    assign out_valid = valid_q;
    assign out_data  = data_q;

    // R7: a refused word is held unchanged
    a_r7_hold_stalled: assert property (@(posedge clk) disable iff (rst || flush)
        (valid_q && !out_ready) |=> (valid_q && $stable(data_q)));
endmodule

// File: rtl/esc_tlast_encoder.sv
module esc_tlast_encoder
    import esc_enc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic [WORD_W-1:0] in_tdata,
    input  logic              in_tlast,
    input  logic              in_tvalid,
    output logic              in_tready,
    output logic [WORD_W-1:0] out_tdata,
    output logic              out_tvalid,
    input  logic              out_tready
);
    word_kind_e        in_kind;
    word_sel_e         sel;
    seq_state_e        seq_state;
    logic              want;
    logic              accept;
    logic              slot_free;
    logic [WORD_W-1:0] next_word;

    esc_classify u_classify (
        .beat_data (in_tdata),
        .beat_last (in_tlast),
        .beat_kind (in_kind)
    );

    esc_sequencer u_seq (
        .clk       (clk),
        .rst       (rst),
        .flush     (clear),
        .in_valid  (in_tvalid),
        .kind      (in_kind),
        .slot_free (slot_free),
        .want      (want),
        .sel       (sel),
        .accept    (accept),
        .state     (seq_state)
    );

    assign next_word = pick_word(sel, in_kind, in_tdata);

    esc_out_stage u_out (
        .clk       (clk),
        .rst       (rst),
        .flush     (clear),
        .load      (want),
        .load_data (next_word),
        .out_ready (out_tready),
        .out_valid (out_tvalid),
        .out_data  (out_tdata),
        .slot_free (slot_free)
    );

    assign in_tready = accept;

    // R6: an accepted word is the next word on the output
    a_r6_accept_loads_data: assert property (@(posedge clk) disable iff (rst || clear)
        (in_tvalid && in_tready) |=> (out_tvalid && out_tdata == $past(in_tdata)));

    // R6: no accept while escape or flag is still pending
    a_r6_stall_in_prefix: assert property (@(posedge clk) disable iff (rst || clear)
        (seq_state == SQ_FLAG || (seq_state == SQ_HEAD && in_kind != KIND_PLAIN)) |-> !in_tready);

    // R4: flag value follows the last bit, with end framing taking priority
    a_r4_flag_matches_last: assert property (@(posedge clk) disable iff (rst || clear)
        (want && slot_free && sel == SEL_FLAG) |=>
            (out_tvalid && out_tdata == ($past(in_tlast) ? FLAG_END : FLAG_LIT)));

    // R9: reset or clear empties the output register
    a_r9_flush_idle: assert property (@(posedge clk)
        (rst || clear) |=> !out_tvalid);
endmodule

// File: tb/tb_esc_tlast_encoder.sv
module tb_esc_tlast_encoder;
    import esc_enc_pkg::*;

    logic              clk = 1'b0;
    logic              rst, clear;
    logic [WORD_W-1:0] in_tdata;
    logic              in_tlast, in_tvalid, in_tready;
    logic [WORD_W-1:0] out_tdata;
    logic              out_tvalid, out_tready;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    logic [WORD_W-1:0] src_d[$];
    logic              src_l[$];
    logic [WORD_W-1:0] exp_w[$];
    logic [WORD_W-1:0] ref_d[$];
    logic              ref_l[$];
    int                dec_st = 0;
    logic              dec_last = 1'b0;

    localparam logic [63:0] ESC_C = 64'hDEADBEEFFEEDCAFE;

    always #4 clk = ~clk;

    esc_tlast_encoder dut (
        .clk(clk), .rst(rst), .clear(clear),
        .in_tdata(in_tdata), .in_tlast(in_tlast), .in_tvalid(in_tvalid), .in_tready(in_tready),
        .out_tdata(out_tdata), .out_tvalid(out_tvalid), .out_tready(out_tready)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    // bench-side encoding, from the requirements
    task automatic push_word(input logic [63:0] d, input logic l);
        src_d.push_back(d); src_l.push_back(l);
        ref_d.push_back(d); ref_l.push_back(l);
        if (l) begin
            exp_w.push_back(ESC_C); exp_w.push_back(64'h1); exp_w.push_back(d);
        end else if (d == ESC_C) begin
            exp_w.push_back(ESC_C); exp_w.push_back(64'h0); exp_w.push_back(d);
        end else begin
            exp_w.push_back(d);
        end
    endtask

    task automatic decode(input logic [63:0] w);
        case (dec_st)
            0: if (w == ESC_C) dec_st = 1;
               else begin
                   chk(ref_d.size() > 0 && ref_d[0] == w && !ref_l[0], "R10 decoded plain", w,
                       ref_d.size() > 0 ? ref_d[0] : 64'h0);
                   if (ref_d.size() > 0) begin void'(ref_d.pop_front()); void'(ref_l.pop_front()); end
               end
            1: begin dec_last = (w[31:0] == 32'h1); dec_st = 2; end
            default: begin
                chk(ref_d.size() > 0 && ref_d[0] == w && ref_l[0] == dec_last, "R10 decoded escaped", w,
                    ref_d.size() > 0 ? ref_d[0] : 64'h0);
                if (ref_d.size() > 0) begin void'(ref_d.pop_front()); void'(ref_l.pop_front()); end
                dec_st = 0;
            end
        endcase
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; clear = 1'b0; in_tvalid = 1'b0; in_tlast = 1'b0; in_tdata = '0; out_tready = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        src_d.delete(); src_l.delete(); exp_w.delete(); ref_d.delete(); ref_l.delete();
        dec_st = 0;
    endtask

    task automatic run_stream(input int vpct, input int rpct, input int max_cycles);
        bit vld = 0;
        bit stall_prev = 0;
        logic [63:0] stall_data = '0;
        int cyc = 0;
        while ((src_d.size() > 0 || exp_w.size() > 0) && cyc < max_cycles) begin
            @(negedge clk);
            cyc++;
            if (!vld && src_d.size() > 0) vld = ($urandom_range(99) < vpct);
            in_tvalid  = vld;
            in_tdata   = vld ? src_d[0] : {$urandom, $urandom};
            in_tlast   = vld ? src_l[0] : 1'($urandom_range(1));
            out_tready = ($urandom_range(99) < rpct);
            #1;
            if (stall_prev)
                chk(out_tvalid && out_tdata == stall_data, "R7 held word", out_tdata, stall_data);
            stall_prev = out_tvalid && !out_tready;
            stall_data = out_tdata;
            if (out_tvalid && out_tready) begin
                // R1 R2 R3 R4 R5: exact encoded order
                chk(exp_w.size() > 0 && exp_w[0] == out_tdata, "R1-R5 encoded word", out_tdata,
                    exp_w.size() > 0 ? exp_w[0] : 64'h0);
                if (exp_w.size() > 0) void'(exp_w.pop_front());
                decode(out_tdata);
            end
            if (in_tvalid && in_tready) begin
                void'(src_d.pop_front()); void'(src_l.pop_front());
                vld = 0;
            end
        end
        @(negedge clk);
        in_tvalid = 1'b0; out_tready = 1'b0;
        chk(exp_w.size() == 0 && ref_d.size() == 0, "R10 stream drained",
            64'(exp_w.size() + ref_d.size()), 64'h0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        do_reset();
        #1;
        chk(out_tvalid == 1'b0, "R9 reset state", 64'(out_tvalid), 64'h0);

        // R6 R7: end word under stall
        @(negedge clk);
        in_tvalid = 1'b1; in_tlast = 1'b1; in_tdata = 64'h0000_1111_2222_3333; out_tready = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); #1;
            chk(out_tvalid && out_tdata == ESC_C, "R7 escape held", out_tdata, ESC_C);
            chk(in_tready == 1'b0, "R6 stalled during escape", 64'(in_tready), 64'h0);
        end
        out_tready = 1'b1; #1;
        chk(in_tready == 1'b0, "R6 stalled while flag loads", 64'(in_tready), 64'h0);
        @(negedge clk); #1;
        chk(out_tdata == 64'h1, "R2 end flag", out_tdata, 64'h1);
        chk(in_tready == 1'b1, "R6 accept with data word", 64'(in_tready), 64'h1);
        @(negedge clk);
        in_tvalid = 1'b0; #1;
        chk(out_tvalid && out_tdata == 64'h0000_1111_2222_3333, "R2 data after flag", out_tdata, 64'h0000_1111_2222_3333);
        @(negedge clk);

        // R9: clear abandons a sequence
        in_tvalid = 1'b1; in_tlast = 1'b1; in_tdata = 64'hAAAA; out_tready = 1'b0;
        @(negedge clk); #1;
        chk(out_tdata == ESC_C, "R9 escape before clear", out_tdata, ESC_C);
        clear = 1'b1;
        @(negedge clk);
        clear = 1'b0; in_tlast = 1'b0; in_tdata = 64'h1234; out_tready = 1'b1; #1;
        chk(out_tvalid == 1'b0, "R9 clear empties output", 64'(out_tvalid), 64'h0);
        chk(in_tready == 1'b1, "R9 fresh start accepts plain", 64'(in_tready), 64'h1);
        @(negedge clk);
        in_tvalid = 1'b0; #1;
        chk(out_tvalid && out_tdata == 64'h1234, "R9 no leftover flag", out_tdata, 64'h1234);

        // R8 R1: full rate plain words
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            in_tvalid = 1'b1; in_tlast = 1'b0; in_tdata = 64'(100 + i); out_tready = 1'b1; #1;
            chk(in_tready == 1'b1, "R8 one word per cycle", 64'(in_tready), 64'h1);
            if (i > 0) chk(out_tvalid && out_tdata == 64'(99 + i), "R1 plain passthrough", out_tdata, 64'(99 + i));
        end
        @(negedge clk);
        in_tvalid = 1'b0;

        // directed corner list at full throughput (R3 R4 R5)
        do_reset();
        push_word(64'h5, 1'b0);
        push_word(64'h6, 1'b1);
        push_word(ESC_C, 1'b0);
        push_word(ESC_C, 1'b1);
        push_word(64'h7, 1'b1);
        push_word(64'h8, 1'b1);
        push_word(ESC_C, 1'b0);
        push_word(ESC_C, 1'b0);
        push_word(64'h1, 1'b0);
        push_word(64'h0, 1'b1);
        run_stream(100, 100, 2000);

        // random with backpressure (R10)
        for (int pass = 0; pass < 3; pass++) begin
            do_reset();
            for (int i = 0; i < 400; i++) begin
                logic [63:0] d;
                d = ($urandom_range(7) == 0) ? ESC_C : {$urandom, $urandom};
                push_word(d, ($urandom_range(3) == 0));
            end
            run_stream(pass == 0 ? 100 : 60, pass == 2 ? 30 : 70, 20000);
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule